// File: doc/BRIEF.md
# Audio DAC Power-Up Sequencer

This block brings an audio converter from reset to a live, unmuted output. It runs on a free-running system clock and watches two external clocks: the converter's master clock and its frame clock. Each is taken through a synchronizer, and the block decides from rising-edge activity whether that clock is present. Once both clocks are present, the sequencer releases the converter's internal reset. After a fixed settling delay, counted in system-clock cycles, it enables the analog section. After a fixed number of frame-clock periods it enables the digital section and the charge pump. It then holds the output muted for a settle interval. That interval is a number of frame-clock periods set by the sample-rate speed mode. When the interval ends, the block unmutes and reports ready.

A separate timer runs from reset release. It opens a register-write window only after a configured delay, and write requests made before then are dropped. If either external clock stops for longer than the activity window, the sequencer falls back to power-down and mutes. It restarts the sequence when both clocks return.

Top module: `dac_powerup_seq`

## Requirements
- R1: While `rst_n` is sampled low on a rising `clk` edge, the block enters power-down: `state_oh` = 5'b00001, `int_rst_n`, `ana_en`, `dig_cp_en`, `ready`, `reg_wr_en` and `wr_accept` low, and `mute` high. The `state_oh` bit positions are 0 power-down, 1 reset released, 2 analog on, 3 digital and charge pump on, and 4 active.
- R2: The block stays in power-down until both `mclk` and `lrck` have shown a rising edge within the activity window. Either clock alone is not enough.
- R3: After leaving power-down, `int_rst_n` is high and `ana_en` low for exactly ANA_CYC = SYS_CLK_KHZ*ANA_DELAY_US/1000 system-clock cycles. `ana_en` rises at the end of that interval.
- R4: `dig_cp_en` rises on the CP_DELAY-th (default 9) detected `lrck` rising edge counted while `ana_en` is high. A pin edge takes effect on the third `clk` rising edge after it appears.
- R5: `ready` rises on the N-th detected `lrck` rising edge counted while `dig_cp_en` is high. N is SETTLE_BASE (64) for `speed_mode` 2'b00, twice that for 2'b01, and four times that for 2'b10 and 2'b11. The mode is sampled when `dig_cp_en` rises, and later changes do not affect that interval.
- R6: `mute` stays high and `ready` low in every state except active. In the active state `mute` is low, `ready` is high, `int_rst_n`, `ana_en` and `dig_cp_en` are all high, and `state_oh` = 5'b10000.
- R7: If either clock shows no rising edge for ACT_WINDOW system-clock cycles, the block returns to power-down with all enables low and `mute` high. It starts again when both clocks are back.
- R8: `reg_wr_en` rises after exactly REG_CYC = SYS_CLK_KHZ*REG_DELAY_US/1000 system-clock cycles with `rst_n` high. It then stays high until the next reset, whether or not the external clocks are present.
- R9: `wr_accept` is high only when `wr_req` is high and `reg_wr_en` is high, so write requests made before the window opens are ignored.
- R10: While both clocks stay active, the active state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mclk | input | 1 | Converter master clock, asynchronous |
| lrck | input | 1 | Converter frame clock, asynchronous |
| speed_mode | input | 2 | 00 normal, 01 double, 10/11 quad |
| wr_req | input | 1 | Configuration write request |
| state_oh | output | 5 | One-hot sequencer state |
| int_rst_n | output | 1 | Converter internal reset release (active low reset) |
| ana_en | output | 1 | Analog section enable |
| dig_cp_en | output | 1 | Digital section and charge-pump enable |
| mute | output | 1 | Forces zero output data when high |
| ready | output | 1 | High only in the active state |
| reg_wr_en | output | 1 | Register-write window open |
| wr_accept | output | 1 | Write request accepted |

## Verification
The full sequence is run once for each of the four speed-mode codes. Measured intervals are compared against the arithmetic expectations: 64, 128, 256 and 256 frame periods. This separates a doubling error from a mode-decode error, and shows that the reserved code behaves as quad. Two runs change the speed mode while the settle count is running. They show whether the mode was latched or is being read live. Runs that remove only the frame clock and runs that remove only the master clock show that each loss detector works on its own. With only the master clock present, the block must stay in power-down. Write requests are held high from reset so the exact cycle the write window opens can be measured.

// File: rtl/dacseq_pkg.sv
// Shared types for the DAC power-up sequencer.
// Assumes: state encoding values double as one-hot bit positions.
package dacseq_pkg;
    typedef enum logic [2:0] {
        ST_PDN    = 3'd0,
        ST_RSTREL = 3'd1,
        ST_ANA    = 3'd2,
        ST_CP     = 3'd3,
        ST_ACT    = 3'd4
    } seq_state_t;

    localparam int NUM_STATES = 5;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_t;
endpackage

// File: rtl/dacseq_delay.sv
// Delay timer in system-clock cycles with a clear input.
// 'hit' is high during the LIMIT-th cycle after clear is released;
// 'done' is a sticky registered flag set on that cycle's edge.
// Assumes LIMIT >= 1; synchronous active-low reset.
module dacseq_delay #(
    parameter int LIMIT = 4000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic hit,
    output logic done
);
    logic [CW-1:0] cnt;

    // Terminal cycle detect.
    assign hit = !clear && !done && (cnt == CW'(LIMIT - 1));

    // Count up until terminal, then hold the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
            if (hit) done <= 1'b1;
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT));
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done);
endmodule

// File: rtl/dacseq_clk_detect.sv
// Clock-activity detector for one asynchronous clock.
// Two-stage synchronizer plus a history flop yields a one-cycle 'rise'
// pulse; 'alive' sets on a rise and clears after WINDOW cycles without one.
// Assumes the monitored clock is slower than half the system clock.
module dacseq_clk_detect #(
    parameter int WINDOW = 8192,
    localparam int WW = $clog2(WINDOW)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_in,
    output logic rise,
    output logic alive
);
    logic [2:0]    sr;
    logic [WW-1:0] idle;

    // Synchronize and keep one stage of history.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[1:0], clk_in};
    end

    assign rise = sr[1] & ~sr[2];

    // Activity window timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alive <= 1'b0;
            idle  <= '0;
        end else if (rise) begin
            alive <= 1'b1;
            idle  <= '0;
        end else if (alive) begin
            if (idle == WW'(WINDOW - 1)) begin
                alive <= 1'b0;
                idle  <= '0;
            end else begin
                idle <= idle + 1'b1;
            end
        end
    end

    p_alive_from_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alive) |-> $past(rise));
    p_drop_on_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alive) |-> !$past(rise));
endmodule

// File: rtl/dac_powerup_seq.sv
// Audio DAC power-up sequencer (top).
// Steps power-down -> reset released -> analog on -> digital/charge pump on
// -> active, with a register-write window timed from reset release.
// Assumes mclk/lrck are asynchronous; synchronous active-low reset.
module dac_powerup_seq
    import dacseq_pkg::*;
#(
    parameter int SYS_CLK_KHZ  = 200000,
    parameter int ANA_DELAY_US = 20,
    parameter int REG_DELAY_US = 10000,
    parameter int ACT_WINDOW   = 8192,
    parameter int CP_DELAY     = 9,
    parameter int SETTLE_BASE  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mclk,
    input  logic                  lrck,
    input  logic [1:0]            speed_mode,
    input  logic                  wr_req,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  int_rst_n,
    output logic                  ana_en,
    output logic                  dig_cp_en,
    output logic                  mute,
    output logic                  ready,
    output logic                  reg_wr_en,
    output logic                  wr_accept
);
    localparam int ANA_CYC    = int'((longint'(SYS_CLK_KHZ) * longint'(ANA_DELAY_US)) / 1000);
    localparam int REG_CYC    = int'((longint'(SYS_CLK_KHZ) * longint'(REG_DELAY_US)) / 1000);
    localparam int SETTLE_MAX = SETTLE_BASE * 4;
    localparam int CNT_MAX    = (SETTLE_MAX > CP_DELAY) ? SETTLE_MAX : CP_DELAY;
    localparam int EW         = $clog2(CNT_MAX + 1);

    seq_state_t    state;
    logic [EW-1:0] ecnt;
    logic [EW-1:0] settle_tgt;
    logic [EW-1:0] settle_sel;
    logic [1:0]    pin_v;
    logic [1:0]    rise_v;
    logic [1:0]    alive_v;
    logic          clocks_ok;
    logic          lr_rise;
    logic          ana_hit;
    logic          ana_done_unused;
    logic          reg_hit_unused;

    // One detector per external clock: index 0 master, index 1 frame.
    assign pin_v = {lrck, mclk};
    for (genvar g = 0; g < 2; g++) begin : g_det
        dacseq_clk_detect #(.WINDOW(ACT_WINDOW)) u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .clk_in (pin_v[g]),
            .rise   (rise_v[g]),
            .alive  (alive_v[g])
        );
    end

    assign clocks_ok = &alive_v;
    assign lr_rise   = rise_v[1];

    // Analog settling timer, running only while reset is released.
    dacseq_delay #(.LIMIT(ANA_CYC)) u_ana_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_RSTREL),
        .hit   (ana_hit),
        .done  (ana_done_unused)
    );

    // Register-write window timer, running from reset release.
    dacseq_delay #(.LIMIT(REG_CYC)) u_reg_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (1'b0),
        .hit   (reg_hit_unused),
        .done  (reg_wr_en)
    );

    // Settle length chosen by speed mode.
    always_comb begin
        case (speed_t'(speed_mode))
            SPD_NORMAL: settle_sel = EW'(SETTLE_BASE);
            SPD_DOUBLE: settle_sel = EW'(SETTLE_BASE * 2);
            default:    settle_sel = EW'(SETTLE_BASE * 4);
        endcase
    end

    // Sequencer state machine with frame-edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PDN;
            ecnt       <= '0;
            settle_tgt <= '0;
        end else if (state != ST_PDN && !clocks_ok) begin
            state <= ST_PDN;
            ecnt  <= '0;
        end else begin
            case (state)
                ST_PDN:    if (clocks_ok) state <= ST_RSTREL;
                ST_RSTREL: if (ana_hit) begin
                    state <= ST_ANA;
                    ecnt  <= '0;
                end
                ST_ANA: if (lr_rise) begin
                    if (ecnt == EW'(CP_DELAY - 1)) begin
                        state      <= ST_CP;
                        ecnt       <= '0;
                        settle_tgt <= settle_sel;
                    end else begin
                        ecnt <= ecnt + 1'b1;
                    end
                end
                ST_CP: if (lr_rise) begin
                    if (ecnt == settle_tgt - 1'b1) state <= ST_ACT;
                    else                           ecnt  <= ecnt + 1'b1;
                end
                default: state <= state;
            endcase
        end
    end

    // State decode to outputs.
    always_comb begin
        state_oh        = '0;
        state_oh[state] = 1'b1;
    end

    assign int_rst_n = (state != ST_PDN);
    assign ana_en    = (state == ST_ANA) || (state == ST_CP) || (state == ST_ACT);
    assign dig_cp_en = (state == ST_CP) || (state == ST_ACT);
    assign ready     = (state == ST_ACT);
    assign mute      = !ready;
    assign wr_accept = wr_req && reg_wr_en;

    p_ana_after_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ana_en) |-> $past(int_rst_n));
    p_cp_after_ana_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dig_cp_en) |-> $past(ana_en) && $past(lr_rise));
    p_unmute_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mute |-> (int_rst_n && ana_en && dig_cp_en));
    p_loss_to_pdn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rst_n && !clocks_ok) |=> !int_rst_n && mute);
    p_write_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> reg_wr_en);
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_oh) && $countones(state_oh) == 1);
endmodule

// File: tb/dac_powerup_seq_test.sv
`timescale 1ns/100ps
module dac_powerup_seq_test;
    localparam int SYS_CLK_KHZ  = 200000;
    localparam int ANA_DELAY_US = 1;
    localparam int REG_DELAY_US = 30;
    localparam int ACT_WINDOW   = 64;
    localparam int CP_DELAY     = 9;
    localparam int SETTLE_BASE  = 64;
    localparam int ANA_CYC      = SYS_CLK_KHZ * ANA_DELAY_US / 1000;
    localparam int REG_CYC      = SYS_CLK_KHZ * REG_DELAY_US / 1000;
    localparam int LR_HALF      = 20;
    localparam int MC_HALF      = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclk = 1'b0;
    logic lrck = 1'b0;
    logic [1:0] speed_mode = 2'b00;
    logic wr_req = 1'b1;
    logic [4:0] state_oh;
    logic int_rst_n, ana_en, dig_cp_en, mute, ready, reg_wr_en, wr_accept;

    logic mclk_on = 1'b0;
    logic lrck_on = 1'b0;
    int mdiv = 0;
    int ldiv = 0;
    int tests = 0;
    int failed = 0;
    int cyc = 0;
    int n_rst = 0, n_ana = 0, n_set = 0, n_reg = 0;
    logic [2:0] lr_p = '0;

    always #2.5 clk = ~clk;

    dac_powerup_seq #(
        .SYS_CLK_KHZ(SYS_CLK_KHZ), .ANA_DELAY_US(ANA_DELAY_US),
        .REG_DELAY_US(REG_DELAY_US), .ACT_WINDOW(ACT_WINDOW),
        .CP_DELAY(CP_DELAY), .SETTLE_BASE(SETTLE_BASE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mclk(mclk), .lrck(lrck),
        .speed_mode(speed_mode), .wr_req(wr_req), .state_oh(state_oh),
        .int_rst_n(int_rst_n), .ana_en(ana_en), .dig_cp_en(dig_cp_en),
        .mute(mute), .ready(ready), .reg_wr_en(reg_wr_en), .wr_accept(wr_accept)
    );

    // External clock generators, stepped on the falling system edge.
    always @(negedge clk) begin
        if (mclk_on) begin
            mdiv = mdiv + 1;
            if (mdiv == MC_HALF) begin mdiv = 0; mclk = ~mclk; end
        end
        if (lrck_on) begin
            ldiv = ldiv + 1;
            if (ldiv == LR_HALF) begin ldiv = 0; lrck = ~lrck; end
        end
    end

    // Interval monitor: frame edges take effect three clk edges after the pin.
    always @(posedge clk) begin
        logic ev;
        ev = lr_p[1] & ~lr_p[2];
        lr_p <= {lr_p[1:0], lrck};
        if (!rst_n) n_reg = 0;
        else if (!reg_wr_en) n_reg = n_reg + 1;
        if (!int_rst_n) begin
            n_rst = 0; n_ana = 0; n_set = 0;
        end else begin
            if (!ana_en) n_rst = n_rst + 1;
            if (ev && ana_en && !dig_cp_en) n_ana = n_ana + 1;
            if (ev && dig_cp_en && !ready) n_set = n_set + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            tests = tests + 1; failed = failed + 1;
            $display("FAIL watchdog R6: cycles %0d, expected fewer than %0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            failed = failed + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Full sequence in one mode; optionally change the mode once charge pump is on.
    task automatic run_mode(input logic [1:0] m, input bit flip, input logic [1:0] m2);
        int exp_set;
        exp_set = (m == 2'b00) ? SETTLE_BASE : (m == 2'b01) ? SETTLE_BASE * 2 : SETTLE_BASE * 4;
        speed_mode = m;
        for (int i = 0; i < 20000 && !dig_cp_en; i++) @(negedge clk);
        chk("R6 muted before active", {31'd0, mute}, 1);
        chk("R6 ready low before active", {31'd0, ready}, 0);
        if (flip) speed_mode = m2;
        for (int i = 0; i < 20000 && !ready; i++) @(negedge clk);
        chk("R3 reset-to-analog cycles", n_rst, ANA_CYC);
        chk("R4 frame edges analog-to-charge-pump", n_ana, CP_DELAY);
        chk("R5 settle frame edges", n_set, exp_set);
        chk("R6 active state code", {27'd0, state_oh}, 5'b10000);
        chk("R6 active enables/unmute", {28'd0, int_rst_n, ana_en, dig_cp_en, mute}, 4'b1110);
        idle(300);
        chk("R10 active holds", {31'd0, ready}, 1);
    endtask

    initial begin
        idle(5);
        chk("R1 reset state code", {27'd0, state_oh}, 5'b00001);
        chk("R1 reset enables", {29'd0, int_rst_n, ana_en, dig_cp_en}, 0);
        chk("R1 reset mute/ready", {30'd0, mute, ready}, 2'b10);
        chk("R1 reset write window", {30'd0, reg_wr_en, wr_accept}, 0);
        rst_n = 1'b1;
        idle(100);
        chk("R2 no clocks stays down", {27'd0, state_oh}, 5'b00001);
        mclk_on = 1'b1;
        idle(200);
        chk("R2 master clock alone stays down", {27'd0, state_oh}, 5'b00001);
        lrck_on = 1'b1;

        run_mode(2'b00, 1'b0, 2'b00);
        chk("R8 window closed early", {31'd0, reg_wr_en}, 0);
        chk("R9 early write ignored", {31'd0, wr_accept}, 0);
        for (int i = 0; i < 20000 && !reg_wr_en; i++) @(negedge clk);
        chk("R8 write window delay", n_reg, REG_CYC);
        chk("R9 write accepted", {31'd0, wr_accept}, 1);
        wr_req = 1'b0; idle(2);
        chk("R9 no request no accept", {31'd0, wr_accept}, 0);
        wr_req = 1'b1;

        // Frame clock loss.
        lrck_on = 1'b0; idle(ACT_WINDOW + 20);
        chk("R7 frame loss state code", {27'd0, state_oh}, 5'b00001);
        chk("R7 frame loss outputs", {28'd0, int_rst_n, ana_en, dig_cp_en, mute}, 4'b0001);
        chk("R8 window survives clock loss", {31'd0, reg_wr_en}, 1);
        lrck_on = 1'b1;
        run_mode(2'b01, 1'b0, 2'b00);

        // Master clock loss.
        mclk_on = 1'b0; idle(ACT_WINDOW + 20);
        chk("R7 master loss state code", {27'd0, state_oh}, 5'b00001);
        chk("R7 master loss mute", {31'd0, mute}, 1);
        mclk_on = 1'b1;
        run_mode(2'b10, 1'b1, 2'b00);

        lrck_on = 1'b0; idle(ACT_WINDOW + 20); lrck_on = 1'b1;
        run_mode(2'b11, 1'b0, 2'b00);

        lrck_on = 1'b0; idle(ACT_WINDOW + 20); lrck_on = 1'b1;
        run_mode(2'b00, 1'b1, 2'b10);

        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule